// File: doc/BRIEF.md
# Block transpose-form FIR filter

This block is a run-time programmable finite-impulse-response filter that takes a block of `L` consecutive signed samples in each clock cycle and returns `L` filtered results in each cycle. The `N` taps are split into `N/L` tap groups. Each group computes its products for all `L` output lanes from the current input block and the block before it. The group results then pass down a chain of registered partial sums, one block register per group boundary. The structure is pipelined by construction and needs only `N/L-1` block delay stages.

Coefficients live in a register bank that is written one tap at a time through an index/value port while the input stream is idle. The response is set entirely by the loaded set, so the same datapath can serve as a low-pass, high-pass, band-pass or band-stop filter. A 16-tap response is obtained by leaving the upper taps at zero. Results are kept at full precision. Rounding and coefficient design are left to the surrounding logic.

Top module: `fir_block_transpose`

## Requirements
- R1: For an input block whose lanes hold stream samples x[p..p+L-1], output lane k equals the sum over taps i = 0..N-1 of h[i]·x[p+k-i]. Lane k occupies bits [k*W+W-1 : k*W] of its bus, where W is the sample width on the input and the accumulator width on the output. Lane 0 carries the oldest sample. Samples before the first block after reset count as zero.
- R2: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and the result of that block is on `out_data` in the same cycle.
- R3: A cycle with `in_valid` low does not advance the filter history. `out_valid` is low in the following cycle, and later blocks continue the stream as if the idle cycles were absent.
- R4: A write with `coef_we` high and `in_valid` low sets tap h[`coef_idx`] to `coef_val`, a signed value. It is used by the products of the next accepted block. Indices at or above N are dropped.
- R5: A coefficient write presented in a cycle with `in_valid` high is ignored, and the tap keeps its previous value.
- R6: Synchronous reset (`rst` high) clears all taps, the sample history and the partial sums to zero, drives `out_valid` low and drives `out_data` to zero.
- R7: Each output lane is DW+CW+ceil(log2 N) bits wide and signed. With every tap and every sample at -32768 (16-bit defaults), each steady-state lane reads exactly N·2^30 without wrapping.
- R8: While `out_valid` is low, `out_data` holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input block present this cycle |
| in_data | input | L*DW | L signed samples, lane 0 oldest |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | $clog2(N) | Tap index of the write |
| coef_val | input | CW | Signed tap value |
| out_valid | output | 1 | Output block present |
| out_data | output | L*AW | L signed full-precision results |

## Verification
The hardest case to reach from the ports is a history that crosses group and block boundaries while the stream stalls. The bench interleaves idle gaps of different lengths between bursts of random blocks. A direct convolution model then checks every lane, so a chain that advances during a gap, or a previous-block register that is wired to the wrong lanes, shows up as a miscompare. A second hard case is a coefficient write that collides with a valid block. The bench issues one in the middle of a stream against a tap whose weight appears in every later output, so a write that was wrongly accepted changes many results.

// File: rtl/fir_blk_pkg.sv
package fir_blk_pkg;

    // Width that holds the sum of 'taps' full products without wrap.
    function automatic int acc_width(input int taps, input int dw, input int cw);
        return dw + cw + $clog2(taps);
    endfunction

endpackage

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
    parameter int N  = 64,
    parameter int CW = 16,
    parameter int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            busy_i,
    input  logic            we_i,
    input  logic [IW-1:0]   idx_i,
    input  logic [CW-1:0]   val_i,
    output logic [N*CW-1:0] coefs_o
);

    typedef struct packed {
        logic [N-1:0][CW-1:0] h;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  wr_ok;

    always_comb begin
        bank_d = bank_q;
        wr_ok  = we_i && !busy_i && (int'(idx_i) < N);
        if (wr_ok) begin
            bank_d.h[idx_i] = val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign coefs_o = bank_q.h;

    // R5: a write that collides with a valid block leaves the bank untouched
    a_r5_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (we_i && busy_i) |=> $stable(bank_q));

    // R4: an idle write lands in the addressed tap
    a_r4_idle_write_lands: assert property (@(posedge clk) disable iff (rst)
        (we_i && !busy_i && (int'(idx_i) < N)) |=> (bank_q.h[$past(idx_i)] == $past(val_i)));

endmodule

// File: rtl/fir_tap_group.sv
module fir_tap_group #(
    parameter int L  = 4,
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int AW = 38
) (
    input  logic [L*CW-1:0] h_i,
    input  logic [L*DW-1:0] cur_i,
    input  logic [L*DW-1:0] prev_i,
    output logic [L*AW-1:0] part_o
);

    localparam int PW = DW + CW;

    logic signed [DW-1:0] smp;
    logic signed [CW-1:0] cf;
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] lane_sum;

    // Lane k, local tap j reads the sample k-j positions back; negative
    // positions fall into the previous block.
    always_comb begin
        part_o   = '0;
        smp      = '0;
        cf       = '0;
        prod     = '0;
        lane_sum = '0;
        for (int k = 0; k < L; k++) begin
            lane_sum = '0;
            for (int j = 0; j < L; j++) begin
                if (k >= j) begin
                    smp = cur_i[(k - j) * DW +: DW];
                end else begin
                    smp = prev_i[(L + k - j) * DW +: DW];
                end
                cf       = h_i[j * CW +: CW];
                prod     = smp * cf;
                lane_sum = lane_sum + {{(AW - PW){prod[PW-1]}}, prod};
            end
            part_o[k * AW +: AW] = lane_sum;
        end
    end

endmodule

// File: rtl/fir_block_transpose.sv
module fir_block_transpose #(
    parameter int L  = 4,
    parameter int N  = 64,
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int AW = fir_blk_pkg::acc_width(N, DW, CW),
    parameter int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [L*DW-1:0] in_data,
    input  logic            coef_we,
    input  logic [IW-1:0]   coef_idx,
    input  logic [CW-1:0]   coef_val,
    output logic            out_valid,
    output logic [L*AW-1:0] out_data
);

    // Number of tap groups; N must be a multiple of L with at least two groups.
    localparam int M = N / L;

    typedef struct packed {
        logic [L*DW-1:0]            prev;
        logic [M-2:0][L*AW-1:0]     chain;
        logic [L*AW-1:0]            y;
        logic                       vld;
    } st_t;

    st_t                    st_d, st_q;
    logic [N*CW-1:0]        coefs;
    logic [M-1:0][L*AW-1:0] parts;

    fir_coef_bank #(.N(N), .CW(CW), .IW(IW)) i_bank (
        .clk     (clk),
        .rst     (rst),
        .busy_i  (in_valid),
        .we_i    (coef_we),
        .idx_i   (coef_idx),
        .val_i   (coef_val),
        .coefs_o (coefs)
    );

    for (genvar g = 0; g < M; g++) begin : g_grp
        fir_tap_group #(.L(L), .DW(DW), .CW(CW), .AW(AW)) i_grp (
            .h_i    (coefs[g * L * CW +: L * CW]),
            .cur_i  (in_data),
            .prev_i (st_q.prev),
            .part_o (parts[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.prev = in_data;
            for (int s = 0; s < M - 2; s++) begin
                for (int k = 0; k < L; k++) begin
                    st_d.chain[s][k * AW +: AW] = parts[s + 1][k * AW +: AW]
                                                + st_q.chain[s + 1][k * AW +: AW];
                end
            end
            st_d.chain[M - 2] = parts[M - 1];
            for (int k = 0; k < L; k++) begin
                st_d.y[k * AW +: AW] = parts[0][k * AW +: AW] + st_q.chain[0][k * AW +: AW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.y;

    // R2: every accepted block yields a result one cycle later
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R3: an idle cycle produces no result and freezes the history
    a_r3_idle_freezes: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(st_q.prev) && $stable(st_q.chain)));

    // R8: results hold while no block is reported
    a_r8_output_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

    // R6: reset empties the output side
    a_r6_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && (out_data == '0)));

endmodule

// File: tb/test_fir_block_transpose.sv
module test_fir_block_transpose;

    localparam int L  = 4;
    localparam int N  = 64;
    localparam int DW = 16;
    localparam int CW = 16;
    localparam int AW = DW + CW + $clog2(N);
    localparam int IW = $clog2(N);

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic [L*DW-1:0] in_data;
    logic            coef_we;
    logic [IW-1:0]   coef_idx;
    logic [CW-1:0]   coef_val;
    logic            out_valid;
    logic [L*AW-1:0] out_data;

    always #10 clk = ~clk;

    fir_block_transpose #(.L(L), .N(N), .DW(DW), .CW(CW)) i_fir_block_transpose (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .coef_we   (coef_we),
        .coef_idx  (coef_idx),
        .coef_val  (coef_val),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    int hm [N];
    int xs [4096];
    int nx;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint expect_at(input int p);
        longint s = 0;
        for (int i = 0; i < N; i++) begin
            if (p - i >= 0) s += longint'(hm[i]) * longint'(xs[p - i]);
        end
        return s;
    endfunction

    function automatic longint lane(input int k);
        logic signed [AW-1:0] t;
        t = out_data[k * AW +: AW];
        return longint'(t);
    endfunction

    function automatic int rnd16();
        return int'($urandom_range(0, 65535)) - 32768;
    endfunction

    task automatic do_reset();
        rst      = 1'b1;
        in_valid = 1'b0;
        in_data  = '0;
        coef_we  = 1'b0;
        coef_idx = '0;
        coef_val = '0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        nx  = 0;
        for (int i = 0; i < N; i++) hm[i] = 0;
        check(out_valid == 1'b0, "R6 valid low", longint'(out_valid), 0);
        check(out_data == '0, "R6 data zero", lane(0), 0);
    endtask

    task automatic load(input int idx, input int val);
        in_valid = 1'b0;
        coef_we  = 1'b1;
        coef_idx = IW'(idx);
        coef_val = val[CW-1:0];
        @(posedge clk);
        #1;
        coef_we = 1'b0;
        hm[idx] = val;
    endtask

    task automatic push(input int blk [L], input bit wr, input int widx, input int wval,
                        input string req);
        in_valid = 1'b1;
        for (int k = 0; k < L; k++) in_data[k * DW +: DW] = blk[k][DW-1:0];
        coef_we  = wr;
        coef_idx = IW'(widx);
        coef_val = wval[CW-1:0];
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        coef_we  = 1'b0;
        for (int k = 0; k < L; k++) xs[nx + k] = blk[k];
        check(out_valid == 1'b1, "R2 valid after block", longint'(out_valid), 1);
        for (int k = 0; k < L; k++) begin
            check(lane(k) == expect_at(nx + k), req, lane(k), expect_at(nx + k));
        end
        nx += L;
    endtask

    task automatic push_rand(input int cnt, input string req);
        int b [L];
        for (int c = 0; c < cnt; c++) begin
            for (int k = 0; k < L; k++) b[k] = rnd16();
            push(b, 1'b0, 0, 0, req);
        end
    endtask

    task automatic idle(input int cycles);
        logic [L*AW-1:0] held;
        held = out_data;
        for (int c = 0; c < cycles; c++) begin
            @(posedge clk);
            #1;
            check(out_valid == 1'b0, "R3 no result when idle", longint'(out_valid), 0);
            check(out_data == held, "R8 output held", lane(0), longint'($signed(held[AW-1:0])));
        end
    endtask

    task automatic load_rand();
        for (int i = 0; i < N; i++) load(i, rnd16());
    endtask

    // R6: zero taps after reset give zero results
    task automatic t_reset_state();
        int b [L] = '{100, 200, 300, 400};
        do_reset();
        push(b, 1'b0, 0, 0, "R6 taps cleared");
    endtask

    // R1 and R4: impulse response walks through every tap
    task automatic t_impulse();
        int one [L]  = '{1, 0, 0, 0};
        int zero [L] = '{0, 0, 0, 0};
        do_reset();
        for (int i = 0; i < N; i++) load(i, i * 37 - 1000);
        push(one, 1'b0, 0, 0, "R4 new taps used by next block");
        for (int c = 0; c < N / L + 1; c++) push(zero, 1'b0, 0, 0, "R1 impulse");
    endtask

    // R1: step through a 16-tap low-pass, then a 16-tap high-pass set
    task automatic t_step();
        int st [L] = '{1000, 1000, 1000, 1000};
        int alt [L] = '{1000, -1000, 1000, -1000};
        do_reset();
        for (int i = 0; i < 16; i++) load(i, (i < 8 ? i + 1 : 16 - i) * 500);
        for (int c = 0; c < 8; c++) push(st, 1'b0, 0, 0, "R1 low-pass step");
        do_reset();
        for (int i = 0; i < 16; i++) load(i, ((i % 2) == 0 ? 700 : -700) * (i < 8 ? i + 1 : 16 - i));
        for (int c = 0; c < 8; c++) push(alt, 1'b0, 0, 0, "R1 high-pass alternating");
    endtask

    // R3 and R8: gaps of different length inside a random stream
    task automatic t_gap();
        do_reset();
        load_rand();
        push_rand(3, "R3 before gap");
        idle(3);
        push_rand(3, "R3 after gap");
        idle(1);
        push_rand(N / L, "R3 across groups");
    endtask

    // R5: a write colliding with a valid block is dropped
    task automatic t_busy_write();
        int b [L];
        do_reset();
        load_rand();
        push_rand(5, "R1 random");
        for (int k = 0; k < L; k++) b[k] = rnd16();
        push(b, 1'b1, 2, 31000, "R5 colliding write");
        push_rand(N / L + 2, "R5 tap unchanged");
    endtask

    // R7: extreme operands fill the accumulator without wrap
    task automatic t_max();
        int mn [L] = '{-32768, -32768, -32768, -32768};
        do_reset();
        for (int i = 0; i < N; i++) load(i, -32768);
        for (int c = 0; c < N / L + 1; c++) push(mn, 1'b0, 0, 0, "R7 full precision");
        check(lane(L - 1) == longint'(N) * (longint'(1) << 30), "R7 exact extreme",
              lane(L - 1), longint'(N) * (longint'(1) << 30));
    endtask

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_data = '0;
        coef_we = 1'b0;
        coef_idx = '0;
        coef_val = '0;
        t_reset_state();
        t_impulse();
        t_step();
        t_gap();
        t_busy_write();
        t_max();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule